// File: doc/BRIEF.md
# CPU exception entry controller

This block sequences exception entry and exception return for a small 32-bit processor core. The pipeline presents one-cycle event requests: a data bus error, an unsigned divide or modulo (the block itself spots a zero divisor), a system call and a breakpoint. All of them come with the address of the instruction that raised them. The block picks one event and computes the handler address from one of two vector base registers. It issues a one-cycle redirect together with a register-file write that saves the faulting address. In the same edge it folds the interrupt-enable bit into a shadow position.

Returns are register-indirect branches. A return through the exception-address register (r30) takes the enable bit back from the normal shadow position. A return through the breakpoint-address register (r31) takes it from the debug shadow position. The block also owns the CSR write path for the enable, pending and two base registers. The pending register is write-one-to-clear. The register file, the decoder and the divider datapath live outside.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A data bus error, a divide with a zero divisor or a system call makes the block write the request's instruction address into register 30. The write appears on the register write port in the cycle after the request.
- R2: A breakpoint writes the instruction address into register 31 and never into register 30.
- R3: On normal exception entry the 3-bit enable register (bit 0 live, bit 1 normal shadow, bit 2 debug shadow) becomes the old bit 0 placed in bit 1, with bits 0 and 2 cleared. This takes precedence over a CSR write to the enable register in the same cycle.
- R4: On breakpoint entry the enable register becomes the old bit 0 placed in bit 2, with bits 0 and 1 cleared.
- R5: For a normal exception the redirect target is the exception base plus 32 times the event identifier. The defaults are 4 for bus error, 5 for divide-by-zero and 7 for system call.
- R6: For a breakpoint the redirect target is the debug base plus 32 times the breakpoint identifier (default 1).
- R7: A return redirects to the given target. Through register 30 the enable register becomes its old bit 1 in bit 0. Through register 31 it becomes its old bit 2 in bit 0. Through any other register it is unchanged.
- R8: A CSR write to the pending register (select 1) clears each bit written as 1 and keeps bits written as 0. A set from the interrupt inputs in the same cycle wins over the clear.
- R9: CSR writes to the enable register (select 0, bits 2:0), the exception base (select 2) and the debug base (select 3) replace the value. Bits 7:0 of both base registers always read zero.
- R10: A divide with a nonzero divisor causes neither a redirect nor a register write.
- R11: Only one event is taken per cycle. The priority is bus error, then divide-by-zero, then system call, then breakpoint. Any exception wins over a return in the same cycle.
- R12: Reset clears the enable, pending and both base registers and deasserts the redirect and register-write outputs.
- R13: Redirect and register-write outputs are registered pulses. In a cycle without an event the target, register index and write data read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_i | input | XLEN | Address of the instruction raising the event |
| bus_err_i | input | 1 | Data bus error request |
| div_i | input | 1 | Unsigned divide or modulo in execute |
| divisor_i | input | XLEN | Divisor operand of that divide |
| scall_i | input | 1 | System call request |
| brk_i | input | 1 | Breakpoint request |
| ret_i | input | 1 | Register-indirect return branch |
| ret_reg_i | input | 5 | Register index the return branches through |
| ret_target_i | input | XLEN | Register value, the return target |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 2 | CSR select: 0 enable, 1 pending, 2 exception base, 3 debug base |
| csr_wdata_i | input | XLEN | CSR write data |
| irq_i | input | NIRQ | Interrupt lines that set pending bits |
| redir_valid_o | output | 1 | One-cycle redirect strobe |
| redir_pc_o | output | XLEN | New fetch address |
| rf_we_o | output | 1 | Register write strobe |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | XLEN | Register write data (saved address) |
| ie_o | output | 3 | Enable register with its shadow bits |
| ip_o | output | NIRQ | Pending register |
| eba_o | output | XLEN | Exception base |
| deba_o | output | XLEN | Debug base |

## Verification
The bench drives simultaneous requests to prove the fixed priority. An inverted order would vector to the wrong identifier's slot and save into the wrong register. Entry is followed by a return through each of r30, r31 and an unrelated register. A design that swapped shadow positions or touched the enable on a plain branch would show a wrong enable value. Unaligned base writes expose a missing low-bit mask through a shifted handler address. Pending-register writes with mixed ones and zeros, some colliding with a live interrupt, catch a plain overwrite or a clear that beats the set. A nonzero divide checks that no stray redirect or register write escapes.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  localparam int IE_W   = 3;
  localparam int RIDX_W = 5;
  localparam logic [RIDX_W-1:0] REG_EA = 5'd30;
  localparam logic [RIDX_W-1:0] REG_BA = 5'd31;

  typedef enum logic [1:0] {
    CSR_IE   = 2'd0,
    CSR_IP   = 2'd1,
    CSR_EBA  = 2'd2,
    CSR_DEBA = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    EK_NONE = 2'd0,
    EK_NORM = 2'd1,
    EK_DBG  = 2'd2
  } exc_kind_e;
endpackage

// File: rtl/exc_prio.sv
`timescale 1ns/1ps
module exc_prio
  import exc_pkg::*;
#(
  parameter int                EID_W     = 3,
  parameter logic [EID_W-1:0]  EID_BUS   = 3'd4,
  parameter logic [EID_W-1:0]  EID_DIVZ  = 3'd5,
  parameter logic [EID_W-1:0]  EID_SCALL = 3'd7,
  parameter logic [EID_W-1:0]  EID_BRK   = 3'd1
) (
  input  logic             bus_i,
  input  logic             divz_i,
  input  logic             scall_i,
  input  logic             brk_i,
  output exc_kind_e        kind_o,
  output logic [EID_W-1:0] eid_o
);
  localparam int NSRC = 4;

  // index 0 is highest priority; last slot is the debug event
  logic [NSRC-1:0]  req;
  logic [EID_W-1:0] eid_tab [NSRC];

  assign req        = {brk_i, scall_i, divz_i, bus_i};
  assign eid_tab[0] = EID_BUS;
  assign eid_tab[1] = EID_DIVZ;
  assign eid_tab[2] = EID_SCALL;
  assign eid_tab[3] = EID_BRK;

  always_comb begin
    kind_o = EK_NONE;
    eid_o  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        eid_o  = eid_tab[i];
        kind_o = (i == NSRC - 1) ? EK_DBG : EK_NORM;
      end
    end
  end
endmodule

// File: rtl/exc_csr.sv
`timescale 1ns/1ps
module exc_csr
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int NIRQ     = 32,
  parameter int BASE_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  exc_kind_e         kind_i,
  input  logic              ret_take_i,
  input  logic [RIDX_W-1:0] ret_reg_i,
  input  logic              csr_we_i,
  input  csr_sel_e          csr_sel_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic [NIRQ-1:0]   irq_i,
  output logic [IE_W-1:0]   ie_o,
  output logic [NIRQ-1:0]   ip_o,
  output logic [XLEN-1:0]   eba_o,
  output logic [XLEN-1:0]   deba_o
);
  localparam logic [XLEN-1:0] BASE_MASK = {{(XLEN-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};
  localparam int NBASE = 2;

  logic [IE_W-1:0] ie_q, ie_d;
  logic [NIRQ-1:0] ip_q, ip_clr;
  logic [XLEN-1:0] base_q [NBASE];

  // entry > return > software write
  always_comb begin
    ie_d = ie_q;
    if (kind_i == EK_NORM)                    ie_d = {1'b0, ie_q[0], 1'b0};
    else if (kind_i == EK_DBG)                ie_d = {ie_q[0], 2'b00};
    else if (ret_take_i && ret_reg_i == REG_EA) ie_d = {2'b00, ie_q[1]};
    else if (ret_take_i && ret_reg_i == REG_BA) ie_d = {2'b00, ie_q[2]};
    else if (csr_we_i && csr_sel_i == CSR_IE) ie_d = csr_wdata_i[IE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ie_q <= '0;
    else         ie_q <= ie_d;
  end

  assign ip_clr = (csr_we_i && csr_sel_i == CSR_IP) ? csr_wdata_i[NIRQ-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ip_q <= '0;
    else         ip_q <= (ip_q & ~ip_clr) | irq_i;
  end

  for (genvar b = 0; b < NBASE; b++) begin : g_base
    localparam csr_sel_e SEL = (b == 0) ? CSR_EBA : CSR_DEBA;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          base_q[b] <= '0;
      else if (csr_we_i && csr_sel_i == SEL) base_q[b] <= csr_wdata_i & BASE_MASK;
    end
  end

  assign ie_o   = ie_q;
  assign ip_o   = ip_q;
  assign eba_o  = base_q[0];
  assign deba_o = base_q[1];
endmodule

// File: rtl/exc_vec.sv
`timescale 1ns/1ps
module exc_vec
  import exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int EID_W     = 3,
  parameter int VEC_SHIFT = 5
) (
  input  exc_kind_e         kind_i,
  input  logic [EID_W-1:0]  eid_i,
  input  logic [XLEN-1:0]   eba_i,
  input  logic [XLEN-1:0]   deba_i,
  input  logic              ret_take_i,
  input  logic [XLEN-1:0]   ret_target_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic              valid_o,
  output logic [XLEN-1:0]   pc_o,
  output logic              we_o,
  output logic [RIDX_W-1:0] waddr_o,
  output logic [XLEN-1:0]   wdata_o
);
  logic [XLEN-1:0] slot_off;
  assign slot_off = XLEN'(eid_i) << VEC_SHIFT;

  always_comb begin
    valid_o = 1'b0;
    pc_o    = '0;
    we_o    = 1'b0;
    waddr_o = '0;
    wdata_o = '0;
    unique case (kind_i)
      EK_NORM: begin
        valid_o = 1'b1;
        pc_o    = eba_i + slot_off;
        we_o    = 1'b1;
        waddr_o = REG_EA;
        wdata_o = pc_i;
      end
      EK_DBG: begin
        valid_o = 1'b1;
        pc_o    = deba_i + slot_off;
        we_o    = 1'b1;
        waddr_o = REG_BA;
        wdata_o = pc_i;
      end
      default: begin
        if (ret_take_i) begin
          valid_o = 1'b1;
          pc_o    = ret_target_i;
        end
      end
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter int               NIRQ      = 32,
  parameter int               EID_W     = 3,
  parameter logic [EID_W-1:0] EID_BUS   = 3'd4,
  parameter logic [EID_W-1:0] EID_DIVZ  = 3'd5,
  parameter logic [EID_W-1:0] EID_SCALL = 3'd7,
  parameter logic [EID_W-1:0] EID_BRK   = 3'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              bus_err_i,
  input  logic              div_i,
  input  logic [XLEN-1:0]   divisor_i,
  input  logic              scall_i,
  input  logic              brk_i,
  input  logic              ret_i,
  input  logic [4:0]        ret_reg_i,
  input  logic [XLEN-1:0]   ret_target_i,
  input  logic              csr_we_i,
  input  logic [1:0]        csr_sel_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic [NIRQ-1:0]   irq_i,
  output logic              redir_valid_o,
  output logic [XLEN-1:0]   redir_pc_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic [2:0]        ie_o,
  output logic [NIRQ-1:0]   ip_o,
  output logic [XLEN-1:0]   eba_o,
  output logic [XLEN-1:0]   deba_o
);
  exc_kind_e         kind;
  logic [EID_W-1:0]  eid;
  logic              divz, ret_take;
  logic              v_d, we_d;
  logic [XLEN-1:0]   pc_d, wd_d;
  logic [RIDX_W-1:0] wa_d;

  assign divz     = div_i && (divisor_i == '0);
  assign ret_take = ret_i && (kind == EK_NONE);

  exc_prio #(
    .EID_W(EID_W), .EID_BUS(EID_BUS), .EID_DIVZ(EID_DIVZ),
    .EID_SCALL(EID_SCALL), .EID_BRK(EID_BRK)
  ) u_prio (
    .bus_i  (bus_err_i),
    .divz_i (divz),
    .scall_i(scall_i),
    .brk_i  (brk_i),
    .kind_o (kind),
    .eid_o  (eid)
  );

  exc_csr #(.XLEN(XLEN), .NIRQ(NIRQ)) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .ret_take_i (ret_take),
    .ret_reg_i  (ret_reg_i),
    .csr_we_i   (csr_we_i),
    .csr_sel_i  (csr_sel_e'(csr_sel_i)),
    .csr_wdata_i(csr_wdata_i),
    .irq_i      (irq_i),
    .ie_o       (ie_o),
    .ip_o       (ip_o),
    .eba_o      (eba_o),
    .deba_o     (deba_o)
  );

  exc_vec #(.XLEN(XLEN), .EID_W(EID_W)) u_vec (
    .kind_i      (kind),
    .eid_i       (eid),
    .eba_i       (eba_o),
    .deba_i      (deba_o),
    .ret_take_i  (ret_take),
    .ret_target_i(ret_target_i),
    .pc_i        (pc_i),
    .valid_o     (v_d),
    .pc_o        (pc_d),
    .we_o        (we_d),
    .waddr_o     (wa_d),
    .wdata_o     (wd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_valid_o <= 1'b0;
      redir_pc_o    <= '0;
      rf_we_o       <= 1'b0;
      rf_waddr_o    <= '0;
      rf_wdata_o    <= '0;
    end else begin
      redir_valid_o <= v_d;
      redir_pc_o    <= pc_d;
      rf_we_o       <= we_d;
      rf_waddr_o    <= wa_d;
      rf_wdata_o    <= wd_d;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk #(
  parameter int               XLEN    = 32,
  parameter int               NIRQ    = 32,
  parameter int               EID_W   = 3,
  parameter logic [EID_W-1:0] EID_BUS = 3'd4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic            bus_err_i,
  input logic            div_i,
  input logic [XLEN-1:0] divisor_i,
  input logic            scall_i,
  input logic            brk_i,
  input logic            ret_i,
  input logic [4:0]      ret_reg_i,
  input logic            csr_we_i,
  input logic [1:0]      csr_sel_i,
  input logic [XLEN-1:0] csr_wdata_i,
  input logic [NIRQ-1:0] irq_i,
  input logic            redir_valid_o,
  input logic [XLEN-1:0] redir_pc_o,
  input logic            rf_we_o,
  input logic [4:0]      rf_waddr_o,
  input logic [XLEN-1:0] rf_wdata_o,
  input logic [2:0]      ie_o,
  input logic [NIRQ-1:0] ip_o,
  input logic [XLEN-1:0] eba_o,
  input logic [XLEN-1:0] deba_o
);
  logic norm_req, brk_only;
  assign norm_req = bus_err_i || (div_i && divisor_i == '0) || scall_i;
  assign brk_only = brk_i && !norm_req;

  AST_SAVE_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_req |=> rf_we_o && rf_waddr_o == 5'd30 && rf_wdata_o == $past(pc_i)); // R1
  AST_BRK_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_only |=> rf_we_o && rf_waddr_o == 5'd31); // R2
  AST_IE_NORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_req |=> ie_o == {1'b0, $past(ie_o[0]), 1'b0}); // R3
  AST_IE_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_only |=> ie_o == {$past(ie_o[0]), 2'b00}); // R4
  AST_VEC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> redir_valid_o && redir_pc_o[4:0] == 5'd0); // R5
  AST_RET_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && ret_reg_i == 5'd30 && !norm_req && !brk_i) |=> ie_o == {2'b00, $past(ie_o[1])}); // R7
  AST_IP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_sel_i == 2'd1 && irq_i == '0) |=> (ip_o & $past(csr_wdata_i[NIRQ-1:0])) == '0); // R8
  AST_BASE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eba_o[7:0] == 8'd0 && deba_o[7:0] == 8'd0); // R9
  AST_DIV_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i && divisor_i != '0 && !bus_err_i && !scall_i && !brk_i && !ret_i) |=> !redir_valid_o && !rf_we_o); // R10
  AST_PRIO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_i |=> rf_waddr_o == 5'd30 && redir_pc_o == $past(eba_o) + (XLEN'(EID_BUS) << 5)); // R11
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN(XLEN), .NIRQ(NIRQ), .EID_W(EID_W), .EID_BUS(EID_BUS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .bus_err_i(bus_err_i),
  .div_i(div_i), .divisor_i(divisor_i), .scall_i(scall_i), .brk_i(brk_i),
  .ret_i(ret_i), .ret_reg_i(ret_reg_i), .csr_we_i(csr_we_i),
  .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i), .irq_i(irq_i),
  .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o), .rf_we_o(rf_we_o),
  .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .ie_o(ie_o),
  .ip_o(ip_o), .eba_o(eba_o), .deba_o(deba_o)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0, divisor_i = '0, ret_target_i = '0, csr_wdata_i = '0, irq_i = '0;
  logic        bus_err_i = 0, div_i = 0, scall_i = 0, brk_i = 0, ret_i = 0, csr_we_i = 0;
  logic [4:0]  ret_reg_i = '0;
  logic [1:0]  csr_sel_i = '0;
  logic        redir_valid_o, rf_we_o;
  logic [31:0] redir_pc_o, rf_wdata_o, ip_o, eba_o, deba_o;
  logic [4:0]  rf_waddr_o;
  logic [2:0]  ie_o;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc_i), .bus_err_i(bus_err_i), .div_i(div_i),
    .divisor_i(divisor_i), .scall_i(scall_i), .brk_i(brk_i), .ret_i(ret_i),
    .ret_reg_i(ret_reg_i), .ret_target_i(ret_target_i), .csr_we_i(csr_we_i),
    .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i), .irq_i(irq_i),
    .redir_valid_o(redir_valid_o), .redir_pc_o(redir_pc_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .ie_o(ie_o), .ip_o(ip_o),
    .eba_o(eba_o), .deba_o(deba_o)
  );

  int n_chk = 0, n_err = 0;
  logic [169:0] exp_q [$];
  string        tag_q [$];
  logic [2:0]   m_ie = '0;
  logic [31:0]  m_ip = '0, m_eba = '0, m_deba = '0;

  function automatic logic [169:0] act_vec();
    return {redir_valid_o, redir_pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, ie_o, ip_o, eba_o, deba_o};
  endfunction

  // driver: drive one cycle, predict the outputs after the next edge
  task automatic cyc(string tag, logic [31:0] pc = 0, bit be = 0, bit dv = 0,
                     logic [31:0] dvs = 1, bit sc = 0, bit bk = 0, bit rt = 0,
                     logic [4:0] rr = 0, logic [31:0] rtg = 0, bit cw = 0,
                     logic [1:0] cs = 0, logic [31:0] cd = 0, logic [31:0] irq = 0);
    int          kind = 0;
    logic [31:0] eid = 0;
    logic        rv = 0, we = 0;
    logic [31:0] rpc = 0, wd = 0;
    logic [4:0]  wa = 0;
    logic [2:0]  nie;
    @(negedge clk);
    pc_i = pc; bus_err_i = be; div_i = dv; divisor_i = dvs; scall_i = sc; brk_i = bk;
    ret_i = rt; ret_reg_i = rr; ret_target_i = rtg; csr_we_i = cw; csr_sel_i = cs;
    csr_wdata_i = cd; irq_i = irq;
    if (be)                   begin kind = 1; eid = 4; end
    else if (dv && dvs == 0)  begin kind = 1; eid = 5; end
    else if (sc)              begin kind = 1; eid = 7; end
    else if (bk)              begin kind = 2; eid = 1; end
    nie = m_ie;
    if (kind == 1) begin
      rv = 1; rpc = m_eba + eid * 32; we = 1; wa = 30; wd = pc; nie = {1'b0, m_ie[0], 1'b0};
    end else if (kind == 2) begin
      rv = 1; rpc = m_deba + eid * 32; we = 1; wa = 31; wd = pc; nie = {m_ie[0], 2'b00};
    end else if (rt) begin
      rv = 1; rpc = rtg;
      if (rr == 30)                nie = {2'b00, m_ie[1]};
      else if (rr == 31)           nie = {2'b00, m_ie[2]};
      else if (cw && cs == 0)      nie = cd[2:0];
    end else if (cw && cs == 0) nie = cd[2:0];
    m_ie = nie;
    m_ip = (m_ip & ~((cw && cs == 1) ? cd : 32'h0)) | irq;
    if (cw && cs == 2) m_eba  = cd & 32'hFFFF_FF00;
    if (cw && cs == 3) m_deba = cd & 32'hFFFF_FF00;
    exp_q.push_back({rv, rpc, we, wa, wd, m_ie, m_ip, m_eba, m_deba});
    tag_q.push_back(tag);
  endtask

  // monitor: compare one item per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [169:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (act_vec() !== e) begin
          n_err++;
          $display("FAIL %s act=%h exp=%h", t, act_vec(), e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (act_vec() !== '0) begin
      n_err++;
      $display("FAIL R12 reset act=%h exp=%h", act_vec(), 170'h0);
    end
    rst_ni = 1'b1;
    cyc(.tag("R12 idle after reset"));
    cyc(.tag("R9 eba write masked"),  .cw(1), .cs(2), .cd(32'h0000_1234));
    cyc(.tag("R9 deba write masked"), .cw(1), .cs(3), .cd(32'hABCD_EFFF));
    cyc(.tag("R9 ie write"),          .cw(1), .cs(0), .cd(32'h1));
    cyc(.tag("R1 R3 R5 scall"),       .pc(32'h100), .sc(1));
    cyc(.tag("R7 ret r30"),           .rt(1), .rr(30), .rtg(32'h104));
    cyc(.tag("R2 R4 R6 brk"),         .pc(32'h200), .bk(1));
    cyc(.tag("R7 ret r31"),           .rt(1), .rr(31), .rtg(32'h204));
    cyc(.tag("R10 div zero"),         .pc(32'h300), .dv(1), .dvs(0));
    cyc(.tag("R7 ret other reg"),     .rt(1), .rr(5), .rtg(32'h55));
    cyc(.tag("R7 ret r30 restores"),  .rt(1), .rr(30), .rtg(32'h304));
    cyc(.tag("R10 div nonzero"),      .pc(32'h400), .dv(1), .dvs(7));
    cyc(.tag("R11 all events"),       .pc(32'h500), .be(1), .dv(1), .dvs(0), .sc(1), .bk(1), .rt(1), .rr(30), .rtg(32'h9));
    cyc(.tag("R11 divz over scall"),  .pc(32'h600), .dv(1), .dvs(0), .sc(1), .bk(1));
    cyc(.tag("R11 scall over brk"),   .pc(32'h700), .sc(1), .bk(1));
    cyc(.tag("R3 exception beats ie write"), .pc(32'h800), .bk(1), .cw(1), .cs(0), .cd(32'h7));
    cyc(.tag("R9 ie write all"),      .cw(1), .cs(0), .cd(32'h7));
    cyc(.tag("R3 entry from ie=7"),   .pc(32'h900), .be(1));
    cyc(.tag("R13 pulse drops"));
    cyc(.tag("R8 irq sets"),          .irq(32'h0000_00F0));
    cyc(.tag("R8 w1c mixed"),         .cw(1), .cs(1), .cd(32'h0000_0030));
    cyc(.tag("R8 zero write no effect"), .cw(1), .cs(1), .cd(32'h0));
    cyc(.tag("R8 set beats clear"),   .cw(1), .cs(1), .cd(32'h0000_0080), .irq(32'h0000_0080));
    cyc(.tag("R5 rebased eba"),       .cw(1), .cs(2), .cd(32'h8000_0000));
    cyc(.tag("R5 bus error vector"),  .pc(32'hA00), .be(1));
    cyc(.tag("R13 idle"));
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule